// File: doc/BRIEF.md
# Cache Block Zero Execution Controller

This controller carries out one "zero a whole cache block" operation for a processor pipeline. A request brings a base register value, the hart's current privilege level and three enable bits, one each from the machine, supervisor and hypervisor environment configuration. The controller first checks whether the operation is permitted at that privilege level. A denied request ends at once with an illegal-instruction or virtual-instruction exception code. A permitted request continues to the next steps.

A permitted request has its address rounded down to the 64-byte block boundary. The controller asks an external translation port for a physical address for a store. It then asks an external permission-check port to approve the whole block. If both steps succeed, it writes zeros over the block as eight 64-bit beats. Each beat waits for the memory port to be ready. The beats do not form one atomic write. The operation ends with a one-cycle completion pulse carrying an exception flag and a 5-bit code. The controller then returns to idle for the next request.

Top module: `blkzero_ctrl`

## Requirements
- R1: The address sent for translation is the request's base value with its low 6 bits cleared. No misaligned-address exception is ever reported.
- R2: Privilege is encoded as M=0, S=1, U=2, VS=3, VU=4. In M mode the operation runs whatever the three enable bits hold.
- R3: With the machine enable at 0, a request from S, U, VS or VU mode is denied with the illegal-instruction code 2. Privilege codes 5 to 7 are also denied with code 2.
- R4: With the machine enable at 1, S mode runs. U mode runs only when the supervisor enable is 1; otherwise it is denied with code 2.
- R5: With the machine enable at 1, VS mode needs the hypervisor enable, and VU mode needs both the supervisor and hypervisor enables. A denial here reports the virtual-instruction code 22.
- R6: A denied request raises its done pulse in the first cycle after acceptance. It makes no translation request, no permission request and no write.
- R7: A permitted request makes exactly one translation request, as a store, for the aligned address. A guest-stage failure reports code 23. This takes priority over a page fault, which reports code 15. Either failure ends the operation with no permission request and no write.
- R8: After a good translation, the permission request carries the block-aligned physical base. A rejection reports the store access fault code 7 with no write.
- R9: The fill issues 8 beats at addresses physical base + 8*i for i = 0..7, in rising order. Each beat has all-zero data and all 8 byte strobes set. A beat advances only when the port is ready. While a beat is stalled, its valid and address stay fixed.
- R10: Completion is a single-cycle done pulse. A successful operation shows exception flag 0 and code 0.
- R11: The controller signals ready only while idle. It is ready again in the cycle after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_base | input | 64 | Base register value |
| req_priv | input | 3 | Privilege level code |
| req_en_m | input | 1 | Machine-level enable |
| req_en_s | input | 1 | Supervisor-level enable |
| req_en_h | input | 1 | Hypervisor-level enable |
| xlat_req | output | 1 | Translation request (store) |
| xlat_vaddr | output | 64 | Aligned virtual address |
| xlat_rsp | input | 1 | Translation response valid |
| xlat_paddr | input | 56 | Translated physical address |
| xlat_page_flt | input | 1 | Translation page fault |
| xlat_guest_flt | input | 1 | Guest-stage translation fault |
| perm_req | output | 1 | Permission check request (store, whole block) |
| perm_paddr | output | 56 | Aligned physical base to check |
| perm_rsp | input | 1 | Permission response valid |
| perm_flt | input | 1 | Permission denied |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write port ready |
| wr_addr | output | 56 | Write beat address |
| wr_data | output | 64 | Write beat data |
| wr_strb | output | 8 | Write byte strobes |
| done | output | 1 | Operation complete pulse |
| done_exc | output | 1 | Exception flag with done |
| done_code | output | 5 | Exception code with done |

## Verification
Several properties are checked on every cycle: a stalled write beat holds its address, accepted beats step by 8 bytes within the block, and only one of translation, permission, write and done is active at a time. The checks also cover that done lasts one cycle and is followed by ready, and that any reported exception code is one of the five allowed values. The bench scenarios are needed for the rest. These are the full privilege and enable matrix, the choice between codes 2 and 22, and the guest-over-page fault priority. They also show that each fault leaves no write behind and that the aligned addresses reach both external ports.

// File: rtl/blkzero_pkg.sv
// Shared types for the cache block zero controller.
// Assumes the standard exception code numbering of the host core.
package blkzero_pkg;

    typedef enum logic [2:0] {
        PRV_M  = 3'd0,
        PRV_S  = 3'd1,
        PRV_U  = 3'd2,
        PRV_VS = 3'd3,
        PRV_VU = 3'd4
    } priv_e;

    localparam logic [4:0] EXC_NONE       = 5'd0;
    localparam logic [4:0] EXC_ILLEGAL    = 5'd2;
    localparam logic [4:0] EXC_ST_ACCESS  = 5'd7;
    localparam logic [4:0] EXC_ST_PAGE    = 5'd15;
    localparam logic [4:0] EXC_VIRTUAL    = 5'd22;
    localparam logic [4:0] EXC_ST_GUEST   = 5'd23;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_XLAT = 3'd1,
        ST_PERM = 3'd2,
        ST_FILL = 3'd3,
        ST_DONE = 3'd4
    } state_e;

endpackage

// File: rtl/blkzero_gate.sv
// Privilege gate: decides whether the zero operation may run at the given
// privilege level and, if not, which trap code applies.
// Assumes: purely combinational, evaluated in the accept cycle.
module blkzero_gate
    import blkzero_pkg::*;
(
    input  logic [2:0] priv,
    input  logic       en_m,
    input  logic       en_s,
    input  logic       en_h,
    output logic       permit,
    output logic [4:0] trap_code
);

    // Enable matrix decode with trap type selection.
    always_comb begin
        permit    = 1'b0;
        trap_code = EXC_ILLEGAL;
        case (priv)
            PRV_M: begin
                permit    = 1'b1;
                trap_code = EXC_NONE;
            end
            PRV_S: begin
                permit    = en_m;
                trap_code = en_m ? EXC_NONE : EXC_ILLEGAL;
            end
            PRV_U: begin
                permit    = en_m & en_s;
                trap_code = (en_m & en_s) ? EXC_NONE : EXC_ILLEGAL;
            end
            PRV_VS: begin
                permit = en_m & en_h;
                if (!en_m)
                    trap_code = EXC_ILLEGAL;
                else if (!en_h)
                    trap_code = EXC_VIRTUAL;
                else
                    trap_code = EXC_NONE;
            end
            PRV_VU: begin
                permit = en_m & en_s & en_h;
                if (!en_m)
                    trap_code = EXC_ILLEGAL;
                else if (!(en_s & en_h))
                    trap_code = EXC_VIRTUAL;
                else
                    trap_code = EXC_NONE;
            end
            default: begin
                permit    = 1'b0;
                trap_code = EXC_ILLEGAL;
            end
        endcase
    end

endmodule

// File: rtl/blkzero_xlat_flt.sv
// Translation fault selector: maps translation response flags to a store
// fault code; the guest-stage fault wins over a plain page fault.
// Assumes: flags are only meaningful with a response valid.
module blkzero_xlat_flt
    import blkzero_pkg::*;
(
    input  logic       guest_flt,
    input  logic       page_flt,
    output logic       fault,
    output logic [4:0] code
);

    // Priority select of the translation fault code.
    always_comb begin
        fault = guest_flt | page_flt;
        if (guest_flt)
            code = EXC_ST_GUEST;
        else if (page_flt)
            code = EXC_ST_PAGE;
        else
            code = EXC_NONE;
    end

endmodule

// File: rtl/blkzero_beat.sv
// Beat counter for the zero fill: counts accepted beats and flags the last.
// Assumes: clr and adv are never asserted together.
module blkzero_beat #(
    parameter int BEATS = 8,
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [CNT_W-1:0] idx,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

    // Beat index register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (adv)
            idx <= idx + 1'b1;
    end

    // Last-beat flag.
    always_comb last = (idx == LAST_IDX);

endmodule

// File: rtl/blkzero_ctrl.sv
// Cache block zero controller (top). Sequences the privilege gate,
// store translation, whole-block permission check and zero fill, and then
// reports completion with an optional exception code.
// Assumes: one request at a time; the external ports answer each request
// exactly once with a one-cycle response.
module blkzero_ctrl
    import blkzero_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int PA_W      = 56,
    parameter int BLK_BYTES = 64,
    parameter int DATA_W    = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [XLEN-1:0]       req_base,
    input  logic [2:0]            req_priv,
    input  logic                  req_en_m,
    input  logic                  req_en_s,
    input  logic                  req_en_h,
    output logic                  xlat_req,
    output logic [XLEN-1:0]       xlat_vaddr,
    input  logic                  xlat_rsp,
    input  logic [PA_W-1:0]       xlat_paddr,
    input  logic                  xlat_page_flt,
    input  logic                  xlat_guest_flt,
    output logic                  perm_req,
    output logic [PA_W-1:0]       perm_paddr,
    input  logic                  perm_rsp,
    input  logic                  perm_flt,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [PA_W-1:0]       wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W/8-1:0]   wr_strb,
    output logic                  done,
    output logic                  done_exc,
    output logic [4:0]            done_code
);

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BEATS      = BLK_BYTES / BEAT_BYTES;
    localparam int CNT_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BOFF_W     = $clog2(BEAT_BYTES);
    localparam logic [XLEN-1:0] VMASK = XLEN'(BLK_BYTES - 1);
    localparam logic [PA_W-1:0] PMASK = PA_W'(BLK_BYTES - 1);

    state_e            state;
    logic [XLEN-1:0]   vbase_q;
    logic [PA_W-1:0]   pbase_q;
    logic              exc_q;
    logic [4:0]        code_q;

    logic              gate_ok;
    logic [4:0]        gate_code;
    logic              xl_fault;
    logic [4:0]        xl_code;
    logic [CNT_W-1:0]  beat_idx;
    logic              beat_last;
    logic              beat_clr;
    logic              beat_adv;
    logic              accept;

    blkzero_gate u_gate (
        .priv      (req_priv),
        .en_m      (req_en_m),
        .en_s      (req_en_s),
        .en_h      (req_en_h),
        .permit    (gate_ok),
        .trap_code (gate_code)
    );

    blkzero_xlat_flt u_xflt (
        .guest_flt (xlat_guest_flt),
        .page_flt  (xlat_page_flt),
        .fault     (xl_fault),
        .code      (xl_code)
    );

    blkzero_beat #(.BEATS(BEATS)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (beat_clr),
        .adv   (beat_adv),
        .idx   (beat_idx),
        .last  (beat_last)
    );

    // Handshake strobes derived from the current state.
    always_comb begin
        accept   = (state == ST_IDLE) && req_valid;
        beat_clr = (state == ST_PERM) && perm_rsp && !perm_flt;
        beat_adv = (state == ST_FILL) && wr_ready;
    end

    // Main sequencer: gate, translate, check, fill, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            vbase_q <= '0;
            pbase_q <= '0;
            exc_q   <= 1'b0;
            code_q  <= EXC_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        vbase_q <= req_base & ~VMASK;
                        if (gate_ok) begin
                            exc_q  <= 1'b0;
                            code_q <= EXC_NONE;
                            state  <= ST_XLAT;
                        end else begin
                            exc_q  <= 1'b1;
                            code_q <= gate_code;
                            state  <= ST_DONE;
                        end
                    end
                end
                ST_XLAT: begin
                    if (xlat_rsp) begin
                        if (xl_fault) begin
                            exc_q  <= 1'b1;
                            code_q <= xl_code;
                            state  <= ST_DONE;
                        end else begin
                            pbase_q <= xlat_paddr & ~PMASK;
                            state   <= ST_PERM;
                        end
                    end
                end
                ST_PERM: begin
                    if (perm_rsp) begin
                        if (perm_flt) begin
                            exc_q  <= 1'b1;
                            code_q <= EXC_ST_ACCESS;
                            state  <= ST_DONE;
                        end else begin
                            state <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (wr_ready && beat_last) begin
                        exc_q  <= 1'b0;
                        code_q <= EXC_NONE;
                        state  <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from state and held registers.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        xlat_req   = (state == ST_XLAT);
        xlat_vaddr = vbase_q;
        perm_req   = (state == ST_PERM);
        perm_paddr = pbase_q;
        wr_valid   = (state == ST_FILL);
        wr_addr    = pbase_q + ({{(PA_W-CNT_W){1'b0}}, beat_idx} << BOFF_W);
        wr_data    = '0;
        wr_strb    = '1;
        done       = (state == ST_DONE);
        done_exc   = exc_q;
        done_code  = code_q;
    end

endmodule

// File: rtl/blkzero_chk.sv
// Checker for the cache block zero controller, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module blkzero_chk #(
    parameter int PA_W      = 56,
    parameter int DATA_W    = 64,
    parameter int BLK_BYTES = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            xlat_req,
    input logic            perm_req,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [PA_W-1:0] wr_addr,
    input logic            done,
    input logic            done_exc,
    input logic [4:0]      done_code
);

    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_BYTES - DATA_W / 8);
    localparam logic [PA_W-1:0]  STEP     = PA_W'(DATA_W / 8);

    // R9: stalled beat holds valid and address
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));

    // R9: accepted beat that is not the last is followed by the next address
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && (wr_addr[OFF_W-1:0] != LAST_OFF)
        |=> wr_valid && (wr_addr == $past(wr_addr) + STEP));

    // R6: the phases never overlap
    a_r6_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xlat_req, perm_req, wr_valid, done}));

    // R10: done lasts a single cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: ready again right after done
    a_r11_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R11: not ready while any phase is active
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req || perm_req || wr_valid || done) |-> !req_ready);

    // R1: reported codes are only the allowed trap and fault codes
    a_r1_codes: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_exc |-> (done_code == 5'd2 || done_code == 5'd22 ||
                              done_code == 5'd7 || done_code == 5'd15 ||
                              done_code == 5'd23));

endmodule

bind blkzero_ctrl blkzero_chk #(
    .PA_W      (PA_W),
    .DATA_W    (DATA_W),
    .BLK_BYTES (BLK_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .xlat_req  (xlat_req),
    .perm_req  (perm_req),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .done      (done),
    .done_exc  (done_exc),
    .done_code (done_code)
);

// File: tb/tb_blkzero_ctrl.sv
// Directed bench for the cache block zero controller: one task per scenario.
module tb_blkzero_ctrl;

    localparam logic [55:0] XOFS = 56'h40_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_base = '0;
    logic [2:0]  req_priv = '0;
    logic        req_en_m = 1'b0, req_en_s = 1'b0, req_en_h = 1'b0;
    logic        xlat_req;
    logic [63:0] xlat_vaddr;
    logic        xlat_rsp = 1'b0;
    logic [55:0] xlat_paddr = '0;
    logic        xlat_page_flt = 1'b0, xlat_guest_flt = 1'b0;
    logic        perm_req;
    logic [55:0] perm_paddr;
    logic        perm_rsp = 1'b0, perm_flt = 1'b0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [55:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_strb;
    logic        done, done_exc;
    logic [4:0]  done_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // scenario knobs
    int  xl_delay = 0, pk_delay = 0, rdy_mode = 0;
    bit  set_page = 0, set_guest = 0, set_perm = 0;
    // observations
    int          xl_count = 0, pk_count = 0, nbeats = 0;
    logic [63:0] seen_vaddr;
    logic [55:0] seen_paddr;
    logic [55:0] bt_addr [8];
    logic [63:0] bt_data [8];
    logic [7:0]  bt_strb [8];

    blkzero_ctrl dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // translation responder
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            xlat_rsp = 1'b0; xlat_page_flt = 1'b0; xlat_guest_flt = 1'b0;
            if (xlat_req) begin
                if (cnt >= xl_delay) begin
                    cnt = 0;
                    xl_count++;
                    seen_vaddr = xlat_vaddr;
                    xlat_rsp = 1'b1;
                    xlat_paddr = xlat_vaddr[55:0] + XOFS;
                    xlat_page_flt = set_page;
                    xlat_guest_flt = set_guest;
                end else cnt++;
            end
        end
    end

    // permission responder
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            perm_rsp = 1'b0; perm_flt = 1'b0;
            if (perm_req) begin
                if (cnt >= pk_delay) begin
                    cnt = 0;
                    pk_count++;
                    seen_paddr = perm_paddr;
                    perm_rsp = 1'b1;
                    perm_flt = set_perm;
                end else cnt++;
            end
        end
    end

    // write port: ready pattern and beat logger
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            wr_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            #1;
            if (wr_valid && wr_ready) begin
                if (nbeats < 8) begin
                    bt_addr[nbeats] = wr_addr;
                    bt_data[nbeats] = wr_data;
                    bt_strb[nbeats] = wr_strb;
                end
                nbeats++;
            end
        end
    end

    // Issue one request and wait for its done pulse.
    task automatic run_req(input logic [2:0] p, input bit m, input bit s, input bit h,
                           input logic [63:0] base, output bit exc, output logic [4:0] code,
                           output int lat);
        xl_count = 0; pk_count = 0; nbeats = 0;
        @(negedge clk);
        chk("R11 ready before request", {63'd0, req_ready}, 64'd1);
        req_priv = p; req_en_m = m; req_en_s = s; req_en_h = h; req_base = base;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 busy after accept", {63'd0, req_ready}, 64'd0);
        lat = 1;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        exc = done_exc; code = done_code;
        @(negedge clk);
        chk("R10 done single cycle", {63'd0, done}, 64'd0);
        chk("R11 ready after done", {63'd0, req_ready}, 64'd1);
    endtask

    task automatic check_fill(input string tag, input logic [63:0] base);
        logic [55:0] pb = (base[55:0] & ~56'h3f) + XOFS;
        chk({tag, " R9 beat count"}, 64'(nbeats), 64'd8);
        for (int i = 0; i < 8; i++) begin
            chk({tag, " R9 beat addr"}, {8'd0, bt_addr[i]}, {8'd0, pb + 56'(8 * i)});
            chk({tag, " R9 beat data"}, bt_data[i], 64'd0);
            chk({tag, " R9 beat strb"}, {56'd0, bt_strb[i]}, 64'hff);
        end
        chk({tag, " R8 perm addr"}, {8'd0, seen_paddr}, {8'd0, pb});
    endtask

    task automatic expect_deny(input string tag, input logic [2:0] p, input bit m,
                               input bit s, input bit h, input logic [4:0] exp_code);
        bit e; logic [4:0] c; int lat;
        run_req(p, m, s, h, 64'h1000, e, c, lat);
        chk({tag, " R6 denied latency"}, 64'(lat), 64'd1);
        chk({tag, " exc flag"}, {63'd0, e}, 64'd1);
        chk({tag, " code"}, {59'd0, c}, {59'd0, exp_code});
        chk({tag, " R6 no translation"}, 64'(xl_count), 64'd0);
        chk({tag, " R6 no writes"}, 64'(nbeats), 64'd0);
    endtask

    task automatic expect_run(input string tag, input logic [2:0] p, input bit m,
                              input bit s, input bit h, input logic [63:0] base);
        bit e; logic [4:0] c; int lat;
        run_req(p, m, s, h, base, e, c, lat);
        chk({tag, " R10 exc flag"}, {63'd0, e}, 64'd0);
        chk({tag, " R10 code"}, {59'd0, c}, 64'd0);
        chk({tag, " R7 one translation"}, 64'(xl_count), 64'd1);
        chk({tag, " R1 aligned vaddr"}, seen_vaddr, base & ~64'h3f);
        check_fill(tag, base);
    endtask

    task automatic t_reset();
        chk("reset req_ready", {63'd0, req_ready}, 64'd1);
        chk("reset done", {63'd0, done}, 64'd0);
        chk("reset wr_valid", {63'd0, wr_valid}, 64'd0);
        chk("reset xlat_req", {63'd0, xlat_req}, 64'd0);
    endtask

    task automatic t_mmode();
        expect_run("R2 M no enables", 3'd0, 0, 0, 0, 64'hdead_beef_1234_567f);
        expect_run("R1 M aligned in", 3'd0, 1, 1, 1, 64'h0000_0000_0008_0040);
    endtask

    task automatic t_machine_off();
        expect_deny("R3 S m=0", 3'd1, 0, 1, 1, 5'd2);
        expect_deny("R3 U m=0", 3'd2, 0, 1, 1, 5'd2);
        expect_deny("R3 VS m=0", 3'd3, 0, 1, 1, 5'd2);
        expect_deny("R3 VU m=0", 3'd4, 0, 1, 1, 5'd2);
        expect_deny("R3 priv 5", 3'd5, 1, 1, 1, 5'd2);
    endtask

    task automatic t_su();
        expect_run("R4 S m=1", 3'd1, 1, 0, 0, 64'h2000);
        expect_deny("R4 U s=0", 3'd2, 1, 0, 1, 5'd2);
        expect_run("R4 U s=1", 3'd2, 1, 1, 0, 64'h3010);
    endtask

    task automatic t_virt();
        expect_deny("R5 VS h=0", 3'd3, 1, 1, 0, 5'd22);
        expect_run("R5 VS h=1", 3'd3, 1, 0, 1, 64'h4020);
        expect_deny("R5 VU s=0", 3'd4, 1, 0, 1, 5'd22);
        expect_deny("R5 VU h=0", 3'd4, 1, 1, 0, 5'd22);
        expect_run("R5 VU all", 3'd4, 1, 1, 1, 64'h5030);
    endtask

    task automatic t_xlat_faults();
        bit e; logic [4:0] c; int lat;
        xl_delay = 2;
        set_page = 1;
        run_req(3'd0, 1, 1, 1, 64'h6000, e, c, lat);
        chk("R7 page fault code", {59'd0, c}, 64'd15);
        chk("R7 page fault flag", {63'd0, e}, 64'd1);
        chk("R7 no perm after page fault", 64'(pk_count), 64'd0);
        chk("R7 no writes after page fault", 64'(nbeats), 64'd0);
        set_guest = 1;
        run_req(3'd4, 1, 1, 1, 64'h7000, e, c, lat);
        chk("R7 guest over page code", {59'd0, c}, 64'd23);
        chk("R7 no writes after guest fault", 64'(nbeats), 64'd0);
        set_page = 0; set_guest = 0; xl_delay = 0;
    endtask

    task automatic t_access_fault();
        bit e; logic [4:0] c; int lat;
        pk_delay = 3; set_perm = 1;
        run_req(3'd1, 1, 0, 0, 64'h8765_4321, e, c, lat);
        chk("R8 access fault code", {59'd0, c}, 64'd7);
        chk("R8 access fault flag", {63'd0, e}, 64'd1);
        chk("R8 checked aligned paddr", {8'd0, seen_paddr},
            {8'd0, (56'h8765_4321 & ~56'h3f) + XOFS});
        chk("R8 no writes after access fault", 64'(nbeats), 64'd0);
        set_perm = 0; pk_delay = 0;
    endtask

    task automatic t_stall();
        rdy_mode = 1; xl_delay = 1; pk_delay = 1;
        expect_run("R9 stalled fill", 3'd2, 1, 1, 0, 64'hffff_ffff_ffff_ffc8);
        rdy_mode = 0; xl_delay = 0; pk_delay = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mmode();
        t_machine_off();
        t_su();
        t_virt();
        t_xlat_faults();
        t_access_fault();
        t_stall();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule